// File: doc/BRIEF.md
# Programmable ROM Mode Decoder Model

This block is a synthesizable behavioural stand-in for a byte-wide programmable read-only memory. It is meant to sit in front of a device programmer as its device under test. Analog levels are reduced to single-bit flags: `vpp_hi` marks the raised programming supply, and `id_hv` marks the raised voltage on the identifier address line. The block decodes these flags with the two active-low enables into eight operating modes. It holds a small parameterized storage array and presents its data bus as a value plus a drive enable.

Cells start erased (all ones), and a write can only clear bits. A program pulse counts only if the program mode is held for at least `MIN_PULSE` clock edges in a row. A configurable range of "weak" addresses needs several qualifying pulses in a row before the write takes hold. Together these let a programmer's pulse-verify-retry loop be tested. An erase input restores all cells to ones, but only in the erasable variant. The one-time-programmable variant ignores it.

Top module: `prom_model`

## Requirements
- R1: With `vpp_hi`=0, `id_hv`=0, `ce_n`=0 and `oe_n`=0 (read), `dout_en` is 1 and `dout` equals the byte stored at `addr`.
- R2: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=1 (output disable), or with `vpp_hi`=0 and `ce_n`=1 (standby, any `oe_n`), `dout_en` is 0.
- R3: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1 (program), the bus floats. When this mode has been held for `MIN_PULSE` consecutive rising edges, the cell at `addr` becomes its old value AND `din`. The write happens once per pulse, at the MIN_PULSE-th edge.
- R4: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0 (verify), the stored byte at `addr` is driven. With `vpp_hi`=1 and both enables high (inhibit), or with `vpp_hi`=1 and both enables low, the bus floats and no cell changes.
- R5: With `id_hv`=1, `vpp_hi`=0, `ce_n`=0 and `oe_n`=0 (signature), `dout` is 0x97 when `addr[0]`=0 and 0x04 when `addr[0]`=1, with `dout_en`=1.
- R6: After reset every cell reads 0xFF. No write ever turns a stored 0 bit into 1.
- R7: When the erasable variant (`ONE_TIME`=0) samples `erase`=1 on a rising edge, every cell returns to all ones. The one-time variant (`ONE_TIME`=1) ignores `erase`.
- R8: A program pulse held for fewer than `MIN_PULSE` consecutive edges leaves the cell unchanged.
- R9: An address in [`WEAK_BASE`, `WEAK_BASE`+`WEAK_COUNT`) changes only on its `WEAK_PULSES`-th consecutive qualifying pulse. A qualifying pulse to any other address restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; array returns to erased |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High voltage present on identifier address line |
| erase | input | 1 | Erase-all request (erasable variant only) |
| addr | input | ADDR_W | Cell address |
| din | input | DATA_W | Program data |
| dout | output | DATA_W | Output data, valid when dout_en is 1 |
| dout_en | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The monotonic-cell checks apply to a fixed read address. They assume `erase` was low on the previous edge, so the stimulus holds `addr` steady and keeps `erase` low around every read that follows a write. The single-write-per-pulse check assumes that the program mode is left between pulses. The directed tasks always return the pins to standby after each pulse, so two pulses never merge. The signature check assumes `vpp_hi` low, and the stimulus never raises `id_hv` together with `vpp_hi`.

// File: rtl/prom_pkg.sv
package prom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_READ,
      MD_DISABLE,
      MD_SIGNATURE,
      MD_PROGRAM,
      MD_VERIFY,
      MD_INHIBIT,
      MD_CONFLICT
   } prom_mode_e;

   function automatic logic mode_drives_array(input prom_mode_e m);
      return (m == MD_READ) || (m == MD_VERIFY);
   endfunction

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
   import prom_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       vpp_hi,
   input  logic       id_hv,
   output prom_mode_e mode
);

   always_comb begin
      if (vpp_hi) begin
         unique case ({ce_n, oe_n})
            2'b01:   mode = MD_PROGRAM;
            2'b10:   mode = MD_VERIFY;
            2'b11:   mode = MD_INHIBIT;
            default: mode = MD_CONFLICT;
         endcase
      end else if (ce_n) begin
         mode = MD_STANDBY;
      end else if (oe_n) begin
         mode = MD_DISABLE;
      end else if (id_hv) begin
         mode = MD_SIGNATURE;
      end else begin
         mode = MD_READ;
      end
   end

endmodule

// File: rtl/prom_pulse_qual.sv
module prom_pulse_qual #(
   parameter int ADDR_W      = 8,
   parameter int MIN_PULSE   = 4,
   parameter int WEAK_BASE   = 'h40,
   parameter int WEAK_COUNT  = 2,
   parameter int WEAK_PULSES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_active,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_en
);

   localparam int CW = $clog2(MIN_PULSE + 1);
   localparam int TW = $clog2(WEAK_PULSES + 1);

   generate
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 1");
      end
      if (WEAK_PULSES < 1) begin : g_bad_weak
         $error("WEAK_PULSES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_cnt;
   logic          qualify;

   assign qualify = prog_active && (run_cnt == CW'(MIN_PULSE - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!prog_active) begin
         run_cnt <= '0;
      end else if (run_cnt != CW'(MIN_PULSE)) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   generate
      if (WEAK_COUNT == 0) begin : g_no_weak
         assign wr_en = qualify;
      end else begin : g_weak
         logic              is_weak;
         logic              tally_vld;
         logic [ADDR_W-1:0] tally_addr;
         logic [TW-1:0]     tally;
         logic              same_cell;
         logic              last_needed;

         assign is_weak = (int'(addr) >= WEAK_BASE) &&
                          (int'(addr) < WEAK_BASE + WEAK_COUNT);
         assign same_cell = tally_vld && (tally_addr == addr);
         assign last_needed = same_cell ? (int'(tally) + 1 >= WEAK_PULSES)
                                        : (WEAK_PULSES == 1);
         assign wr_en = qualify && (!is_weak || last_needed);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tally_vld  <= 1'b0;
               tally_addr <= '0;
               tally      <= '0;
            end else if (qualify) begin
               if (!is_weak || last_needed) begin
                  tally_vld <= 1'b0;
                  tally     <= '0;
               end else begin
                  tally_vld  <= 1'b1;
                  tally_addr <= addr;
                  tally      <= same_cell ? tally + 1'b1 : TW'(1);
               end
            end
         end

         // R9
         weak_tally_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tally_vld |-> (int'(tally) < WEAK_PULSES));
      end
   endgenerate

   // R3
   one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R8
   commit_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> prog_active);

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter bit ONE_TIME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic              erase_eff;

   generate
      if (ONE_TIME) begin : g_otp
         assign erase_eff = 1'b0;

         // R7
         otp_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == '0));
      end else begin : g_erasable
         assign erase_eff = erase;

         // R6
         no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(rd_addr) && !$past(erase)) |->
               ((rd_data & ~$past(rd_data)) == '0));

         // R7
         erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            erase |=> (rd_data == '1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || erase_eff) begin
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= '1;
         end
      end else if (wr_en) begin
         cells[wr_addr] <= cells[wr_addr] & wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/prom_model.sv
module prom_model
   import prom_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter int               DATA_W      = 8,
   parameter bit               ONE_TIME    = 1'b0,
   parameter int               MIN_PULSE   = 4,
   parameter int               WEAK_BASE   = 'h40,
   parameter int               WEAK_COUNT  = 2,
   parameter int               WEAK_PULSES = 3,
   parameter logic [DATA_W-1:0] MFR_ID     = DATA_W'('h97),
   parameter logic [DATA_W-1:0] DEV_ID     = DATA_W'('h04)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic              erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   generate
      if (ADDR_W < 1 || ADDR_W > 11) begin : g_bad_addr
         $error("ADDR_W must lie in 1..11");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8 to hold identifier codes");
      end
      if (WEAK_COUNT < 0 || WEAK_BASE < 0 || WEAK_BASE + WEAK_COUNT > (1 << ADDR_W)) begin : g_bad_weak
         $error("weak range must lie inside the array");
      end
   endgenerate

   prom_mode_e        mode;
   logic              wr_en;
   logic [DATA_W-1:0] cell_q;

   prom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hi (vpp_hi),
      .id_hv  (id_hv),
      .mode   (mode)
   );

   prom_pulse_qual #(
      .ADDR_W      (ADDR_W),
      .MIN_PULSE   (MIN_PULSE),
      .WEAK_BASE   (WEAK_BASE),
      .WEAK_COUNT  (WEAK_COUNT),
      .WEAK_PULSES (WEAK_PULSES)
   ) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_active (mode == MD_PROGRAM),
      .addr        (addr),
      .wr_en       (wr_en)
   );

   prom_cell_array #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ONE_TIME (ONE_TIME)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (erase),
      .wr_en   (wr_en),
      .wr_addr (addr),
      .wr_data (din),
      .rd_addr (addr),
      .rd_data (cell_q)
   );

   always_comb begin
      dout    = '0;
      dout_en = 1'b0;
      if (mode_drives_array(mode)) begin
         dout    = cell_q;
         dout_en = 1'b1;
      end else if (mode == MD_SIGNATURE) begin
         dout    = addr[0] ? DEV_ID : MFR_ID;
         dout_en = 1'b1;
      end
   end

   // R1
   drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !oe_n);

   // R2
   standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && ce_n) |-> !dout_en);

   // R4
   verify_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && ce_n && !oe_n) |-> dout_en);

   // R3
   program_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && !ce_n && oe_n) |-> !dout_en);

   // R5
   signature_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_hv && !vpp_hi && !ce_n && !oe_n) |->
         (dout_en && dout == (addr[0] ? DEV_ID : MFR_ID)));

endmodule

// File: tb/prom_model_test.sv
module prom_model_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic       vpp_hi = 1'b0;
   logic       id_hv = 1'b0;
   logic       erase = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout, dout_otp;
   logic       dout_en, dout_en_otp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   prom_model #(.ONE_TIME(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
      .id_hv(id_hv), .erase(erase), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   prom_model #(.ONE_TIME(1'b1)) uut_otp (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
      .id_hv(id_hv), .erase(erase), .addr(addr), .din(din),
      .dout(dout_otp), .dout_en(dout_en_otp)
   );

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pins(input logic c, input logic o, input logic v, input logic h,
                       input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      ce_n = c; oe_n = o; vpp_hi = v; id_hv = h; addr = a; din = d;
      #1;
   endtask

   task automatic idle();
      pins(1, 1, 0, 0, addr, din);
   endtask

   task automatic prog_pulse(input logic [7:0] a, input logic [7:0] d, input int n);
      pins(0, 1, 1, 0, a, d);
      check("R3 program floats", {dout_en, 8'h00}, 9'h000);
      repeat (n) @(posedge clk);
      idle();
   endtask

   task automatic read_expect(input string tag, input logic [7:0] a, input logic [7:0] exp);
      pins(0, 0, 0, 0, a, 8'h00);
      check(tag, {dout_en, dout}, {1'b1, exp});
      idle();
   endtask

   task automatic t_reset_state();
      read_expect("R6 erased after reset addr00", 8'h00, 8'hFF);
      read_expect("R6 erased after reset addr7F", 8'h7F, 8'hFF);
      read_expect("R1 erased read addrFF", 8'hFF, 8'hFF);
   endtask

   task automatic t_float_modes();
      pins(0, 1, 0, 0, 8'h03, 8'h00);
      check("R2 output disable", {dout_en, 8'h00}, 9'h000);
      pins(1, 0, 0, 0, 8'h03, 8'h00);
      check("R2 standby oe low", {dout_en, 8'h00}, 9'h000);
      pins(1, 1, 0, 0, 8'h03, 8'h00);
      check("R2 standby oe high", {dout_en, 8'h00}, 9'h000);
      idle();
   endtask

   task automatic t_program_and();
      prog_pulse(8'h12, 8'hA5, 4);
      read_expect("R3 exact pulse writes", 8'h12, 8'hA5);
      prog_pulse(8'h12, 8'h5F, 9);
      read_expect("R3 stored is old AND new", 8'h12, 8'h05);
      prog_pulse(8'h12, 8'hFF, 5);
      read_expect("R6 ones cannot be restored", 8'h12, 8'h05);
      read_expect("R1 neighbour untouched", 8'h13, 8'hFF);
   endtask

   task automatic t_short_pulse();
      prog_pulse(8'h20, 8'h00, 3);
      read_expect("R8 short pulse no write", 8'h20, 8'hFF);
      prog_pulse(8'h20, 8'h3C, 4);
      read_expect("R8 retry with full pulse", 8'h20, 8'h3C);
   endtask

   task automatic t_verify_inhibit();
      pins(1, 0, 1, 0, 8'h12, 8'h00);
      check("R4 verify drives stored", {dout_en, dout}, {1'b1, 8'h05});
      pins(1, 1, 1, 0, 8'h13, 8'h00);
      check("R4 inhibit floats", {dout_en, 8'h00}, 9'h000);
      repeat (6) @(posedge clk);
      pins(0, 0, 1, 0, 8'h13, 8'h00);
      check("R4 both enables low floats", {dout_en, 8'h00}, 9'h000);
      repeat (6) @(posedge clk);
      idle();
      read_expect("R4 inhibit and conflict no write", 8'h13, 8'hFF);
   endtask

   task automatic t_signature();
      pins(0, 0, 0, 1, 8'h00, 8'h00);
      check("R5 manufacturer code", {dout_en, dout}, {1'b1, 8'h97});
      pins(0, 0, 0, 1, 8'h01, 8'h00);
      check("R5 device code", {dout_en, dout}, {1'b1, 8'h04});
      pins(0, 0, 0, 1, 8'h12, 8'h00);
      check("R5 code ignores cell", {dout_en, dout}, {1'b1, 8'h97});
      pins(0, 1, 0, 1, 8'h00, 8'h00);
      check("R2 signature needs oe", {dout_en, 8'h00}, 9'h000);
      idle();
   endtask

   task automatic t_weak();
      prog_pulse(8'h40, 8'h00, 4);
      read_expect("R9 weak after 1 pulse", 8'h40, 8'hFF);
      prog_pulse(8'h40, 8'h00, 4);
      read_expect("R9 weak after 2 pulses", 8'h40, 8'hFF);
      prog_pulse(8'h40, 8'h00, 4);
      read_expect("R9 weak after 3 pulses", 8'h40, 8'h00);
      prog_pulse(8'h41, 8'h0F, 4);
      prog_pulse(8'h30, 8'hF0, 4);
      read_expect("R9 normal cell in between", 8'h30, 8'hF0);
      prog_pulse(8'h41, 8'h0F, 4);
      prog_pulse(8'h41, 8'h0F, 4);
      read_expect("R9 tally restarted", 8'h41, 8'hFF);
      prog_pulse(8'h41, 8'h0F, 4);
      read_expect("R9 weak written after restart", 8'h41, 8'h0F);
   endtask

   task automatic t_erase();
      read_expect("R7 otp holds before erase", 8'h12, 8'h05);
      @(negedge clk);
      erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      pins(0, 0, 0, 0, 8'h12, 8'h00);
      check("R7 erasable cleared", {dout_en, dout}, {1'b1, 8'hFF});
      check("R7 otp ignores erase", {dout_en_otp, dout_otp}, {1'b1, 8'h05});
      pins(0, 0, 0, 0, 8'h40, 8'h00);
      check("R7 erasable weak cell cleared", {dout_en, dout}, {1'b1, 8'hFF});
      check("R7 otp weak cell kept", {dout_en_otp, dout_otp}, {1'b1, 8'h00});
      idle();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_float_modes();
      t_program_and();
      t_short_pulse();
      t_verify_inhibit();
      t_signature();
      t_weak();
      t_erase();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule